// File: doc/BRIEF.md
# Overflow Event Up-Timer

This block is a general-purpose up-counting timer whose event is the counter wrapping past its all-ones value. To get an event C clocks after starting, software puts the value all-ones minus C into the counter and then sets the run bit. On the wrap, a sticky overflow flag is set. The interrupt line follows that flag, gated by an enable bit. Software clears the flag by writing a one to it.

Two modes are available. In one-shot mode the counter wraps to zero and the run bit drops by itself. In periodic mode the counter takes the value of a separate reload register on every wrap and keeps counting. Software can read the counter at any time as a free-running count source, and can write it while it runs.

Access is through a plain single-cycle register bus. A write is taken on a clock edge when `wrEn` is high. Reads are combinational from `addr`.

Top module: `wrap_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: While the run bit (CTRL, address 0x00, bit 0) is 1, the counter (COUNTER, address 0x08) increases by one on each clock. While the run bit is 0, the counter holds its value.
- R3: The overflow flag (STATUS, address 0x0C, bit 0) is set on the clock edge on which a running counter at all-ones wraps. If the counter holds all-ones minus C when the run bit is written to 1, the flag reads 1 exactly C+1 clocks after that write, and not before.
- R4: With the reload bit (CTRL bit 1) set, a wrap loads the counter from the reload register (LOAD, address 0x04), and the run bit stays 1.
- R5: With the reload bit clear, a wrap leaves the counter at zero and clears the run bit.
- R6: Writing 1 to STATUS bit 0 clears the flag, and writing 0 leaves it unchanged. If a wrap and a clearing write fall on the same edge, the flag ends up set.
- R7: `irq` is high exactly when the overflow flag and the enable bit (INTEN, address 0x10, bit 0) are both 1.
- R8: A write to COUNTER shows on the next clock, and counting continues from the written value. On that edge the write takes priority over both the increment and the wrap, and no overflow is flagged.
- R9: A CTRL write on the same edge as a one-shot wrap takes priority over the automatic clearing of the run bit.
- R10: LOAD and INTEN read back what was written, and a LOAD write does not disturb the counter. Reads of unmapped addresses return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wrData | input | CNT_W | Write data |
| rdData | output | CNT_W | Combinational read data for `addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that `addr` and `wrData` carry defined values on every edge where `wrEn` is high. They also assume that the bus carries no more than one write per clock. Under these assumptions, each edge's counter update and run-bit update follow from the previous state alone.

The stimulus drives exactly one write or idle cycle per clock, with every field defined. Counter and reload values are biased to within a few counts of all-ones, so that wraps in both modes occur often. Writes that collide with a wrap are placed on purpose, so that every priority rule is exercised.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;
  localparam int REG_CTRL = 'h00;
  localparam int REG_LOAD = 'h04;
  localparam int REG_CNT  = 'h08;
  localparam int REG_STS  = 'h0C;
  localparam int REG_IEN  = 'h10;

  // strobes from control to datapath, priority cntWr > cntReload > cntInc
  typedef struct packed {
    logic loadWr;
    logic cntWr;
    logic cntReload;
    logic cntInc;
  } dpCmd_t;
endpackage

// File: rtl/wtmr_dp.sv
module wtmr_dp
  import wtmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] loadVal,
  output logic             cntMax
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      loadVal <= '0;
    end else begin
      if (cmd.loadWr) loadVal <= wrData;
      if (cmd.cntWr)          cnt <= wrData;
      else if (cmd.cntReload) cnt <= loadVal;
      else if (cmd.cntInc)    cnt <= cnt + 1'b1;
    end
  end

  assign cntMax = (cnt == ALL_ONES);
endmodule

// File: rtl/wtmr_ctrl.sv
module wtmr_ctrl
  import wtmr_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wrBits,
  input  logic              cntMax,
  output dpCmd_t            cmd,
  output logic              runQ,
  output logic              autoRelQ,
  output logic              stsQ,
  output logic              ienQ,
  output logic              irq
);
  logic hitCtrl, hitLoad, hitCnt, hitSts, hitIen;
  logic wrap;

  assign hitCtrl = wrEn && (addr == ADDR_W'(REG_CTRL));
  assign hitLoad = wrEn && (addr == ADDR_W'(REG_LOAD));
  assign hitCnt  = wrEn && (addr == ADDR_W'(REG_CNT));
  assign hitSts  = wrEn && (addr == ADDR_W'(REG_STS));
  assign hitIen  = wrEn && (addr == ADDR_W'(REG_IEN));

  // a counter write on the wrap edge cancels the wrap
  assign wrap = runQ && cntMax && !hitCnt;

  always_comb begin
    cmd           = '0;
    cmd.loadWr    = hitLoad;
    cmd.cntWr     = hitCnt;
    cmd.cntReload = wrap && autoRelQ;
    cmd.cntInc    = runQ && !hitCnt && !(wrap && autoRelQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      autoRelQ <= 1'b0;
      stsQ     <= 1'b0;
      ienQ     <= 1'b0;
    end else begin
      if (hitCtrl) begin
        runQ     <= wrBits[0];
        autoRelQ <= wrBits[1];
      end else if (wrap && !autoRelQ) begin
        runQ <= 1'b0;
      end
      if (wrap)                     stsQ <= 1'b1;
      else if (hitSts && wrBits[0]) stsQ <= 1'b0;
      if (hitIen) ienQ <= wrBits[0];
    end
  end

  assign irq = stsQ && ienQ;
endmodule

// File: rtl/wrap_timer.sv
module wrap_timer
  import wtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);
  dpCmd_t           cmd;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic             cntMax;
  logic             runQ, autoRelQ, stsQ, ienQ;

  wtmr_ctrl #(.ADDR_W(ADDR_W)) ctrlU (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrBits(wrData[1:0]), .cntMax(cntMax), .cmd(cmd),
    .runQ(runQ), .autoRelQ(autoRelQ), .stsQ(stsQ), .ienQ(ienQ), .irq(irq)
  );

  wtmr_dp #(.CNT_W(CNT_W)) dpU (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .cnt(cnt), .loadVal(loadVal), .cntMax(cntMax)
  );

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(REG_CTRL): rdData = CNT_W'({autoRelQ, runQ});
      ADDR_W'(REG_LOAD): rdData = loadVal;
      ADDR_W'(REG_CNT):  rdData = cnt;
      ADDR_W'(REG_STS):  rdData = CNT_W'(stsQ);
      ADDR_W'(REG_IEN):  rdData = CNT_W'(ienQ);
      default:           rdData = '0;
    endcase
  end
endmodule

// File: rtl/wrap_timer_chk.sv
module wrap_timer_chk
  import wtmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wrData,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  loadVal,
  input logic              runQ,
  input logic              autoRelQ,
  input logic              stsQ,
  input logic              ienQ,
  input logic              irq
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  logic cntHit, ctrlHit, atTop;
  assign cntHit  = wrEn && (addr == ADDR_W'(REG_CNT));
  assign ctrlHit = wrEn && (addr == ADDR_W'(REG_CTRL));
  assign atTop   = (cnt == ALL_ONES);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !atTop && !cntHit) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !cntHit) |=> $stable(cnt));
  // R3
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && atTop && !cntHit) |=> stsQ);
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && autoRelQ && atTop && !cntHit && !ctrlHit) |=> (runQ && cnt == $past(loadVal)));
  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !autoRelQ && atTop && !cntHit && !ctrlHit) |=> (!runQ && cnt == '0));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (stsQ && ienQ));
  // R8
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntHit |=> (cnt == $past(wrData)));
endmodule

bind wrap_timer wrap_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chkU (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .cnt(cnt), .loadVal(loadVal), .runQ(runQ), .autoRelQ(autoRelQ),
  .stsQ(stsQ), .ienQ(ienQ), .irq(irq)
);

// File: tb/wrap_timer_test.sv
`timescale 1ns/100ps
module wrap_timer_test;
  localparam logic [31:0] MAX = 32'hFFFF_FFFF;
  localparam logic [4:0] A_CTRL = 5'h00, A_LOAD = 5'h04, A_CNT = 5'h08,
                         A_STS = 5'h0C, A_IEN = 5'h10, A_NONE = 5'h14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irq;
  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  // reference state
  logic mRun = 0, mAr = 0, mSts = 0, mIen = 0;
  logic [31:0] mLoad = '0, mCnt = '0;

  always #2 clk = ~clk;

  wrap_timer uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
                  .wrData(wrData), .rdData(rdData), .irq(irq));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    wrEn = 1'b0; addr = a; #0.2; v = rdData;
  endtask

  // expected next state from the requirements
  task automatic model(input logic we, input logic [4:0] a, input logic [31:0] d);
    logic cw, wrap;
    cw = we && a == A_CNT;
    wrap = mRun && mCnt == MAX && !cw;
    if (cw) mCnt = d;
    else if (wrap && mAr) mCnt = mLoad;
    else if (mRun) mCnt = mCnt + 1;
    if (we && a == A_CTRL) begin mRun = d[0]; mAr = d[1]; end
    else if (wrap && !mAr) mRun = 0;
    if (wrap) mSts = 1;
    else if (we && a == A_STS && d[0]) mSts = 0;
    if (we && a == A_LOAD) mLoad = d;
    if (we && a == A_IEN) mIen = d[0];
  endtask

  task automatic compareAll();
    logic [31:0] v;
    rd(A_CNT, v);  chk("R2 counter", v, mCnt);
    rd(A_CTRL, v); chk("R5 ctrl", v, {30'b0, mAr, mRun});
    rd(A_STS, v);  chk("R6 status", v, {31'b0, mSts});
    rd(A_LOAD, v); chk("R10 load", v, mLoad);
    chk("R7 irq", {31'b0, irq}, {31'b0, mSts && mIen});
  endtask

  // one clock with optional write, then compare against the model
  task automatic step(input logic we, input logic [4:0] a, input logic [31:0] d);
    wrEn = we; addr = a; wrData = d;
    @(posedge clk);
    model(we, a, d);
    @(negedge clk);
    wrEn = 1'b0;
    compareAll();
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CNT, v);  chk("R1 cnt", v, 0);
    rd(A_STS, v);  chk("R1 sts", v, 0);
    rd(A_IEN, v);  chk("R1 ien", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R3 one-shot delay of C=5: flag at exactly 6 clocks after start
    step(1, A_CNT, MAX - 5);
    step(1, A_CTRL, 32'h1);
    for (int i = 0; i < 5; i++) step(0, A_NONE, 0);
    rd(A_STS, v); chk("R3 not yet", v, 0);
    step(0, A_NONE, 0);
    rd(A_STS, v); chk("R3 flag", v, 1);
    rd(A_CTRL, v); chk("R5 stopped", v, 0);
    rd(A_CNT, v); chk("R5 zero", v, 0);

    // R6 write 0 keeps, write 1 clears
    step(1, A_STS, 0);
    rd(A_STS, v); chk("R6 keep", v, 1);
    // R7 enable gating
    step(1, A_IEN, 1);
    chk("R7 irq on", {31'b0, irq}, 1);
    rd(A_IEN, v); chk("R10 ien", v, 1);
    step(1, A_STS, 1);
    rd(A_STS, v); chk("R6 clear", v, 0);
    chk("R7 irq off", {31'b0, irq}, 0);

    // R4 periodic with reload value MAX-3
    step(1, A_LOAD, MAX - 3);
    rd(A_CNT, v); chk("R10 load no disturb", v, 0);
    step(1, A_CNT, MAX - 3);
    step(1, A_CTRL, 32'h3);
    for (int i = 0; i < 4; i++) step(0, A_NONE, 0);
    rd(A_CNT, v); chk("R4 reloaded", v, MAX - 3);
    rd(A_CTRL, v); chk("R4 still running", v, 3);

    // R6 clear on the wrap edge loses: counter is MAX-3, reaches MAX after 3 steps
    step(1, A_STS, 1);
    step(0, A_NONE, 0); step(0, A_NONE, 0);
    step(1, A_STS, 1);
    rd(A_STS, v); chk("R6 set wins", v, 1);

    // R8 counter write while running, then counting continues
    step(1, A_CNT, 32'd100);
    rd(A_CNT, v); chk("R8 written", v, 100);
    step(0, A_NONE, 0);
    rd(A_CNT, v); chk("R8 continues", v, 101);
    // R8 write at the wrap edge suppresses the flag
    step(1, A_STS, 1);
    step(1, A_CNT, MAX);
    step(1, A_CNT, 32'd7);
    rd(A_STS, v); chk("R8 no flag", v, 0);
    rd(A_CNT, v); chk("R8 write wins", v, 7);

    // R9 ctrl write on one-shot wrap edge keeps run bit
    step(1, A_CTRL, 32'h1);
    step(1, A_CNT, MAX);
    step(1, A_CTRL, 32'h1);
    rd(A_CTRL, v); chk("R9 run kept", v, 1);
    rd(A_STS, v); chk("R9 flag", v, 1);

    // R10 unmapped write ignored and read zero
    step(1, A_NONE, 32'hFFFF_FFFF);
    rd(A_NONE, v); chk("R10 unmapped", v, 0);

    // random mix, checked against model every cycle
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = $urandom % 9;
      case (op)
        3: step(1, A_CNT, MAX - ($urandom % 12));
        4: step(1, A_CTRL, {30'b0, 2'($urandom % 4) | 2'b01});
        5: step(1, A_STS, {31'b0, 1'($urandom % 2)});
        6: step(1, A_IEN, {31'b0, 1'($urandom % 2)});
        7: step(1, A_LOAD, MAX - ($urandom % 10));
        8: step(1, A_CTRL, {30'b0, 2'($urandom % 4)});
        default: step(0, A_NONE, 0);
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule